// File: doc/BRIEF.md
# Lane-tracked staging writer for a 64-bit input queue

The block collects host writes into an 8-byte staging word and feeds completed words into a small first-in, first-out queue. The queue is read by a downstream execution unit. Each host write carries a data word and a byte-enable vector, so a write can fill one byte, an aligned 4-byte half or the full 8 bytes. An internal lane mask records which bytes already hold data. As soon as every lane is filled, the word is queued with no further command, and the mask and staging data return to zero.

At the end of a message the host raises an end-of-message strobe. Any partial word is then queued, and the lanes that were never written are filled with zeros. The block also detects two error cases. If a write touches a lane that is already filled, the block raises a one-cycle error pulse and discards that write. If a word cannot be queued because the queue is full, the block sets a sticky overflow flag. The consumer drains the queue through a valid/ready port.

Top module: `stage_fifo_writer`

## Requirements
- R1: Bit i of `wr_be` enables byte lane i, which is bits 8i+7:8i of `wr_data`. Only enabled lanes are copied into the staging word. The supported patterns are a single bit, 8'h0F, 8'hF0 and 8'hFF.
- R2: When the lane mask becomes 8'hFF, the word is pushed into the queue in that same clock edge. It is visible on `pop_data` with `pop_valid` high from the next cycle. After the push, the mask and the staging data are zero.
- R3: A write whose enables overlap an already-filled lane raises `dup_err` for exactly the cycle after the write. The whole write is discarded, so the staging word and the mask are unchanged.
- R4: A write that would complete the mask but also overlaps a filled lane follows R3. Nothing is queued.
- R5: When `eom` is high and the mask is non-zero, the staging word is queued with all unfilled lanes set to zero. A valid write in the same cycle is merged into the word first.
- R6: When `eom` is high and the mask is zero (counting any same-cycle write), nothing is queued.
- R7: A word that is ready to queue while the queue already holds DEPTH words is discarded. The staging word and the mask are still cleared, and `ovf_flag` is set and stays high until reset.
- R8: Queued words leave in arrival order, one for each cycle in which `pop_valid` and `pop_ready` are both high. While `pop_ready` is low, `pop_data` holds its value.
- R9: After reset, `pop_valid`, `dup_err` and `ovf_flag` are 0 and the staging word is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_be | input | 8 | Byte-lane enables |
| wr_data | input | 64 | Write data, lane i in bits 8i+7:8i |
| eom | input | 1 | End-of-message flush strobe |
| pop_valid | output | 1 | Queue holds at least one word |
| pop_ready | input | 1 | Consumer accepts the head word |
| pop_data | output | 64 | Head word of the queue |
| dup_err | output | 1 | One-cycle pulse on a duplicate-lane write |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
The bench applies several kinds of write pattern:
- Full-width writes separate the immediate-enqueue path from the merge path.
- Low-half then high-half writes show that lanes are merged and that junk in disabled lanes is masked off.
- Single-byte writes followed by a flush show that the padding is zero.
- A repeated lane and a completing-but-overlapping write show that duplicate writes are discarded rather than merged.

Flushes with an empty stage, and a flush in the same cycle as a write, separate R5 from R6. Filling the queue past DEPTH, followed by a partial flush, shows both that the overflowing word is dropped and that the staging word is cleared afterwards.

// File: rtl/stage_fifo_writer.sv
module stage_fifo_writer #(
  parameter int DEPTH = 8,
  parameter int LANES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [LANES-1:0]     wr_be,
  input  logic [LANES*8-1:0]   wr_data,
  input  logic                 eom,
  output logic                 pop_valid,
  input  logic                 pop_ready,
  output logic [LANES*8-1:0]   pop_data,
  output logic                 dup_err,
  output logic                 ovf_flag
);
  localparam int DW = LANES * 8;
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [LANES-1:0] mask, nmask;
  logic [DW-1:0]    stage, ndata;
  logic [DW-1:0]    mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;

  wire dup  = wr_en && |(wr_be & mask);
  wire take = wr_en && !dup;
  wire want = (&nmask) || (eom && |nmask);
  wire full = (cnt == CW'(DEPTH));
  wire push = want && !full;
  wire pop  = pop_valid && pop_ready;

  always_comb begin
    nmask = take ? (mask | wr_be) : mask;
    ndata = stage;
    for (int i = 0; i < LANES; i++)
      if (take && wr_be[i]) ndata[i*8 +: 8] = wr_data[i*8 +: 8];
  end

  assign pop_valid = (cnt != '0);
  assign pop_data  = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask     <= '0;
      stage    <= '0;
      wp       <= '0;
      rp       <= '0;
      cnt      <= '0;
      dup_err  <= 1'b0;
      ovf_flag <= 1'b0;
    end else begin
      dup_err <= dup;
      if (want) begin
        mask  <= '0;
        stage <= '0;
        if (full) ovf_flag <= 1'b1;
      end else begin
        mask  <= nmask;
        stage <= ndata;
      end
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp] <= ndata;

  always_comb
    if (rst_n) assert_cnt_bound_R8: assert (cnt <= CW'(DEPTH));

  assert_dup_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && |(wr_be & mask)) |=> dup_err);

  assert_dup_no_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && |(wr_be & mask) && !eom && !pop_ready) |=> $stable(cnt) && $stable(stage));

  assert_full_word_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be == '1 && mask == '0 && cnt == '0) |=> pop_valid && pop_data == $past(wr_data));

  assert_empty_eom_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eom && !wr_en && mask == '0 && !pop_valid) |=> !pop_valid);

  assert_ovf_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !pop_ready) |=> pop_valid && $stable(pop_data));
endmodule

// File: tb/test_stage_fifo_writer.sv
module test_stage_fifo_writer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_be = '0;
  logic [63:0] wr_data = '0;
  logic        eom = 1'b0;
  logic        pop_ready = 1'b0;
  logic        pop_valid, dup_err, ovf_flag;
  logic [63:0] pop_data;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  stage_fifo_writer #(.DEPTH(8), .LANES(8)) i_stage_fifo_writer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
    .eom(eom), .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
    .dup_err(dup_err), .ovf_flag(ovf_flag));

  // {be, data, eom, expected dup_err}
  localparam logic [73:0] VEC [12] = '{
    {8'hFF, 64'h1111_2222_3333_4444, 1'b0, 1'b0},
    {8'h0F, 64'hFFFF_FFFF_AAAA_BBBB, 1'b0, 1'b0},
    {8'hF0, 64'hCCCC_DDDD_EEEE_EEEE, 1'b0, 1'b0},
    {8'h01, 64'hFFFF_FFFF_FFFF_FF11, 1'b0, 1'b0},
    {8'h01, 64'h0000_0000_0000_0022, 1'b0, 1'b1},
    {8'h02, 64'hFFFF_FFFF_FFFF_33FF, 1'b0, 1'b0},
    {8'h00, 64'h0,                   1'b1, 1'b0},
    {8'h00, 64'h0,                   1'b1, 1'b0},
    {8'hF0, 64'h5566_7788_FFFF_FFFF, 1'b0, 1'b0},
    {8'hFF, 64'h9999_9999_9999_9999, 1'b0, 1'b1},
    {8'h00, 64'h0,                   1'b1, 1'b0},
    {8'h0C, 64'hFFFF_FFFF_9988_FFFF, 1'b1, 1'b0}
  };
  localparam logic [63:0] EXP [5] = '{
    64'h1111_2222_3333_4444, 64'hCCCC_DDDD_AAAA_BBBB, 64'h0000_0000_0000_3311,
    64'h5566_7788_0000_0000, 64'h0000_0000_9988_0000
  };

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] be, logic [63:0] d, logic e);
    wr_en = (be != 0); wr_be = be; wr_data = d; eom = e;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0; eom = 1'b0;
  endtask

  task automatic drain(string tag, logic [63:0] exp);
    chk({tag, " valid"}, 64'(pop_valid), 64'd1);
    chk({tag, " data"}, pop_data, exp);
    pop_ready = 1'b1;
    @(negedge clk);
    pop_ready = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 pop_valid", 64'(pop_valid), 0);
    chk("R9 dup_err", 64'(dup_err), 0);
    chk("R9 ovf_flag", 64'(ovf_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    wr(8'h00, 64'h0, 1'b1);
    chk("R9 R6 empty stage flush", 64'(pop_valid), 0);

    for (int k = 0; k < 12; k++) begin
      wr(VEC[k][73:66], VEC[k][65:2], VEC[k][1]);
      chk($sformatf("R1 R3 R4 dup_err vec %0d", k), 64'(dup_err), 64'(VEC[k][0]));
    end

    chk("R8 stall hold a", pop_data, EXP[0]);
    @(negedge clk);
    chk("R8 stall hold b", pop_data, EXP[0]);
    for (int k = 0; k < 5; k++)
      drain($sformatf("R2 R5 R8 drain %0d", k), EXP[k]);
    chk("R6 R4 no extra word", 64'(pop_valid), 0);

    for (int k = 0; k < 8; k++) wr(8'hFF, 64'h100 + 64'(k), 1'b0);
    chk("R7 no ovf at depth", 64'(ovf_flag), 0);
    wr(8'hFF, 64'hDEAD, 1'b0);
    chk("R7 ovf set", 64'(ovf_flag), 1);
    for (int k = 0; k < 8; k++) drain("R7 R8 kept words", 64'h100 + 64'(k));
    chk("R7 overflow word dropped", 64'(pop_valid), 0);
    wr(8'h0F, 64'hFFFF_FFFF_0000_0077, 1'b1);
    drain("R7 stage cleared after drop", 64'h0000_0000_0000_0077);
    chk("R7 ovf sticky", 64'(ovf_flag), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule